// File: doc/BRIEF.md
# Word-Clock Rate Classifier

This block watches an audio word clock and works out its sample rate against a fixed 24.576 MHz reference clock. It reports two things: the rate multiple (single, double or quad speed) and the base family (44.1 kHz or 48 kHz). A downstream clock-selection or display circuit reads the three outputs. It trusts the class and family only while the valid flag is high.

The word clock is first brought into the reference domain. The reference is prescaled to a one-in-three tick, and a first counter measures the low phase of the word clock in ticks. That count picks the rate multiple. The word clock is then divided by the detected multiple, so the low phase of the divided signal always has the width of a single-speed half period. A second counter measures it, and one fixed threshold then separates the two families at every multiple. Both results pass a two-measurement agreement filter before they reach the outputs. A missing word clock clears the valid flag.

Top module: `wclk_rate_classifier`

## Requirements
- R1: Counters advance only on one reference cycle in every PRESCALE (default 3). They count while the synchronised word clock is low and are held at zero while it is high. The low-phase count is captured at the rising edge. So a 48 kHz word clock (256 reference cycles per half period) yields about 85.
- R2: The class code is 1 (single speed) for a captured count above LIM_X1 (64). It is 2 (double speed) for a count above LIM_X2 (32) and 3 (quad speed) for a count above LIM_X4 (16).
- R3: The second count is taken on the word clock divided by 1, 2 or 4 for codes 1, 2 and 3. A count of FAM_LIMIT (89) or more gives fam_44k=1, and a lower count gives fam_44k=0, at every multiple.
- R4: Both counters saturate at 255 instead of wrapping, so a very long low phase still reads as single speed of the 44.1 kHz family.
- R5: A captured count of 16 or less classifies as code 0. Once committed, code 0 forces rate_valid low.
- R6: The class and the family change only after two consecutive identical measurements. A single differing measurement leaves both outputs unchanged.
- R7: If the word clock has no edge for TIMEOUT_CYC reference cycles, the class is set to 0 and rate_valid drops. Before that limit the outputs are kept.
- R8: While reset is high and just after it, rate_cls=0, fam_44k=0 and rate_valid=0.
- R9: rate_valid is high only when the class code is non-zero and the family has been confirmed since the last class change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Asynchronous audio word clock |
| rate_cls | output | 2 | 0 none, 1 single, 2 double, 3 quad speed |
| fam_44k | output | 1 | 1 for the 44.1 kHz family, 0 for the 48 kHz family |
| rate_valid | output | 1 | Class and family are confirmed |

## Verification
The bench keeps the prescaler, thresholds and synchroniser depth at their defaults, so the six standard rates produce the real counts near 85, 92, 42, 46, 21 and 23. It lowers TIMEOUT_CYC to 4096 so that a stopped word clock can be observed timing out, and then recovering, within a short run. It also checks that the flag is still held well before that limit. A slow clock with a 1000-cycle low phase pushes the counters past 255. A single shortened low phase on a locked 44.1 kHz stream exercises the agreement filter on both the class and the family.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    localparam int unsigned CNT_W    = 8;
    localparam int unsigned DIV_BITS = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_X1   = 2'd1,
        RC_X2   = 2'd2,
        RC_X4   = 2'd3
    } rate_cls_e;

    typedef enum logic {
        FAM_48K = 1'b0,
        FAM_44K = 1'b1
    } fam_e;

    typedef struct packed {
        logic evt;
        cnt_t cnt;
    } meas_t;

    function automatic rate_cls_e classify(cnt_t c, int unsigned lim1,
                                           int unsigned lim2, int unsigned lim4);
        if (32'(c) > lim1)      return RC_X1;
        else if (32'(c) > lim2) return RC_X2;
        else if (32'(c) > lim4) return RC_X4;
        else                    return RC_NONE;
    endfunction

    function automatic fam_e family_of(cnt_t c, int unsigned lim);
        return (32'(c) >= lim) ? FAM_44K : FAM_48K;
    endfunction

endpackage

// File: rtl/wrc_tick_gen.sv
module wrc_tick_gen #(
    parameter int unsigned DIV = 3
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)               ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + 1'b1;
    end

    assign tick = (ph_q == LAST);
endmodule

// File: rtl/wrc_sync_edge.sv
module wrc_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_in};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level = sh_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/wrc_phase_counter.sv
// Counts ticks while lvl is low, clears while high, and reports the
// low-phase count at each rising edge. The first edge after reset or
// restart closes a partial phase and is not reported.
module wrc_phase_counter
    import wrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  lvl,
    input  logic  restart,
    output meas_t meas
);
    cnt_t cnt_q;
    logic lvl_q;
    logic armed_q;
    logic rise;

    assign rise = lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
            armed_q <= 1'b0;
            meas    <= '0;
        end else begin
            lvl_q    <= lvl;
            meas.evt <= 1'b0;
            if (restart) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                if (rise) begin
                    meas.evt <= armed_q;
                    meas.cnt <= cnt_q;
                    armed_q  <= 1'b1;
                end
                if (lvl)                      cnt_q <= '0;
                else if (tick && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wrc_wclk_div.sv
// Ripple of toggle stages on the word clock (a small up-counter); stage k
// divides by 2**(k+1). The class code picks the stage.
module wrc_wclk_div
    import wrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      lvl,
    input  logic      rise,
    input  rate_cls_e sel,
    output logic      div_lvl
);
    logic [DIV_BITS-1:0] tgl_q;

    always_ff @(posedge clk) begin
        if (rst || restart) tgl_q <= '0;
        else if (rise)      tgl_q <= tgl_q + 1'b1;
    end

    always_comb begin
        case (sel)
            RC_X2:   div_lvl = tgl_q[0];
            RC_X4:   div_lvl = tgl_q[DIV_BITS-1];
            default: div_lvl = lvl;
        endcase
    end
endmodule

// File: rtl/wclk_rate_classifier.sv
module wclk_rate_classifier
    import wrc_pkg::*;
#(
    parameter int unsigned PRESCALE    = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LIM_X1      = 64,
    parameter int unsigned LIM_X2      = 32,
    parameter int unsigned LIM_X4      = 16,
    parameter int unsigned FAM_LIMIT   = 89,
    parameter int unsigned TIMEOUT_CYC = 65536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wclk_in,
    output logic [1:0] rate_cls,
    output logic       fam_44k,
    output logic       rate_valid
);
    localparam int unsigned TO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);
    localparam logic [TO_W-1:0] TO_FULL = TO_W'(TIMEOUT_CYC);

    logic      tick;
    logic      wl, wrise, wfall, wedge;
    logic      div_lvl;
    logic      restart2;
    logic      cls_commit;
    logic      stale_evt;
    meas_t     meas1, meas2;
    rate_cls_e raw_cls, cls_q, cls_cand_q;
    fam_e      raw_fam, fam_q, fam_cand_q;
    logic      fam_seen_q, fam_lock_q;
    logic [TO_W-1:0] idle_q;

    wrc_tick_gen #(.DIV(PRESCALE)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    wrc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(wclk_in),
        .level(wl), .rise(wrise), .fall(wfall)
    );

    assign wedge = wrise | wfall;

    wrc_phase_counter u_cnt_rate (
        .clk(clk), .rst(rst), .tick(tick), .lvl(wl),
        .restart(1'b0), .meas(meas1)
    );

    wrc_wclk_div u_div (
        .clk(clk), .rst(rst), .restart(restart2), .lvl(wl),
        .rise(wrise), .sel(cls_q), .div_lvl(div_lvl)
    );

    wrc_phase_counter u_cnt_fam (
        .clk(clk), .rst(rst), .tick(tick), .lvl(div_lvl),
        .restart(restart2), .meas(meas2)
    );

    // ---- word-clock loss ----
    assign stale_evt = !wedge && (idle_q == TO_LAST);

    always_ff @(posedge clk) begin
        if (rst)                  idle_q <= '0;
        else if (wedge)           idle_q <= '0;
        else if (idle_q != TO_FULL) idle_q <= idle_q + 1'b1;
    end

    // ---- rate class with two-sample agreement ----
    assign raw_cls    = classify(meas1.cnt, LIM_X1, LIM_X2, LIM_X4);
    assign cls_commit = meas1.evt && (raw_cls == cls_cand_q) && (raw_cls != cls_q);
    assign restart2   = cls_commit || stale_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q      <= RC_NONE;
            cls_cand_q <= RC_NONE;
        end else if (stale_evt) begin
            cls_q      <= RC_NONE;
            cls_cand_q <= RC_NONE;
        end else if (meas1.evt) begin
            cls_cand_q <= raw_cls;
            if (raw_cls == cls_cand_q) cls_q <= raw_cls;
        end
    end

    // ---- family with two-sample agreement ----
    assign raw_fam = family_of(meas2.cnt, FAM_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            fam_q      <= FAM_48K;
            fam_cand_q <= FAM_48K;
            fam_seen_q <= 1'b0;
            fam_lock_q <= 1'b0;
        end else if (restart2) begin
            fam_seen_q <= 1'b0;
            fam_lock_q <= 1'b0;
        end else if (meas2.evt && cls_q != RC_NONE) begin
            if (fam_seen_q && raw_fam == fam_cand_q) begin
                fam_q      <= raw_fam;
                fam_lock_q <= 1'b1;
            end
            fam_cand_q <= raw_fam;
            fam_seen_q <= 1'b1;
        end
    end

    assign rate_cls   = cls_q;
    assign fam_44k    = (fam_q == FAM_44K);
    assign rate_valid = (cls_q != RC_NONE) && fam_lock_q;
endmodule

// File: rtl/wrc_checks.sv
module wrc_checks #(
    parameter int unsigned LIM_X1 = 64,
    parameter int unsigned LIM_X2 = 32,
    parameter int unsigned LIM_X4 = 16
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] rate_cls,
    input logic       fam_44k,
    input logic       rate_valid,
    input logic       cap1_evt,
    input logic [7:0] cap1_cnt,
    input logic       cap2_evt,
    input logic       stale_evt
);
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (rate_cls == 2'd0 && !fam_44k && !rate_valid));

    a_r9_valid_needs_class: assert property (@(posedge clk) disable iff (rst)
        rate_valid |-> (rate_cls != 2'd0));

    a_r6_class_moves_on_capture: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_cls) |-> $past(cap1_evt || stale_evt));

    a_r6_family_moves_on_capture: assert property (@(posedge clk) disable iff (rst)
        !$stable(fam_44k) |-> $past(cap2_evt));

    a_r2_x1_band: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_cls) != 2'd1 && rate_cls == 2'd1) |-> (32'($past(cap1_cnt)) > LIM_X1));

    a_r2_x4_band: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_cls) != 2'd3 && rate_cls == 2'd3)
        |-> (32'($past(cap1_cnt)) > LIM_X4 && 32'($past(cap1_cnt)) <= LIM_X2));

    a_r7_timeout_clears: assert property (@(posedge clk) disable iff (rst)
        stale_evt |=> (rate_cls == 2'd0 && !rate_valid));
endmodule

bind wclk_rate_classifier wrc_checks #(
    .LIM_X1(LIM_X1), .LIM_X2(LIM_X2), .LIM_X4(LIM_X4)
) u_wrc_checks (
    .clk(clk), .rst(rst), .rate_cls(rate_cls), .fam_44k(fam_44k),
    .rate_valid(rate_valid), .cap1_evt(meas1.evt), .cap1_cnt(meas1.cnt),
    .cap2_evt(meas2.evt), .stale_evt(stale_evt)
);

// File: tb/test_wclk_rate_classifier.sv
`timescale 1ns/1ps
module test_wclk_rate_classifier;

    typedef struct {
        logic [1:0] cls;
        logic       fam;
        logic       vld;
        logic       chk_fam;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wclk = 1'b0;
    logic [1:0] rate_cls;
    logic fam_44k, rate_valid;

    always #10 clk = ~clk;

    wclk_rate_classifier #(.TIMEOUT_CYC(4096)) i_wclk_rate_classifier (
        .clk(clk), .rst(rst), .wclk_in(wclk),
        .rate_cls(rate_cls), .fam_44k(fam_44k), .rate_valid(rate_valid)
    );

    int lo_n = 256, hi_n = 256, glitch_n = 0;
    bit run = 1'b0;
    int checks = 0, errors = 0;
    bit finished = 1'b0;
    exp_t sb_q[$];

    task automatic expect_out(logic [1:0] c, logic f, logic v, logic cf, string tag);
        exp_t e;
        e.cls = c; e.fam = f; e.vld = v; e.chk_fam = cf; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_rate(int lo, int hi);
        lo_n = lo; hi_n = hi; run = 1'b1;
    endtask

    // word-clock driver, in reference-clock cycles
    initial begin
        forever begin
            if (!run) @(negedge clk);
            else begin
                int lo_now;
                lo_now = (glitch_n > 0) ? glitch_n : lo_n;
                glitch_n = 0;
                wclk = 1'b0;
                repeat (lo_now) @(negedge clk);
                wclk = 1'b1;
                repeat (hi_n) @(negedge clk);
            end
        end
    end

    // monitor: compare expected items against the outputs
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rate_cls !== e.cls || rate_valid !== e.vld ||
                (e.chk_fam && fam_44k !== e.fam)) begin
                errors++;
                $display("FAIL %s: cls=%0d fam=%0d valid=%0d expected cls=%0d fam=%0d valid=%0d",
                         e.tag, rate_cls, fam_44k, rate_valid, e.cls, e.fam, e.vld);
            end
        end
    end

    initial begin
        cycles(5);
        rst = 1'b0;
        expect_out(2'd0, 1'b0, 1'b0, 1'b1, "R8 reset state");
        cycles(2);

        // 48 kHz family at each multiple
        set_rate(256, 256); cycles(7000);
        expect_out(2'd1, 1'b0, 1'b1, 1'b1, "R1/R2/R3/R9 48k single");
        set_rate(128, 128); cycles(7000);
        expect_out(2'd2, 1'b0, 1'b1, 1'b1, "R2/R3 96k double");
        set_rate(64, 64); cycles(7000);
        expect_out(2'd3, 1'b0, 1'b1, 1'b1, "R2/R3 192k quad");

        // 44.1 kHz family at each multiple
        set_rate(279, 278); cycles(7000);
        expect_out(2'd1, 1'b1, 1'b1, 1'b1, "R1/R3 44.1k single");
        set_rate(139, 140); cycles(7000);
        expect_out(2'd2, 1'b1, 1'b1, 1'b1, "R2/R3 88.2k double");
        set_rate(69, 70); cycles(7000);
        expect_out(2'd3, 1'b1, 1'b1, 1'b1, "R2/R3 176.4k quad");

        // one short low phase on a locked 44.1k stream: nothing moves
        set_rate(279, 278); cycles(7000);
        glitch_n = 64;
        for (int i = 0; i < 40; i++) begin
            expect_out(2'd1, 1'b1, 1'b1, 1'b1, "R6 single odd measurement");
            cycles(100);
        end

        // very long low phase: saturation keeps single speed, 44.1k family
        set_rate(1000, 200); cycles(10000);
        expect_out(2'd1, 1'b1, 1'b1, 1'b1, "R4 saturated count");

        // word clock too fast
        set_rate(30, 30); cycles(2000);
        expect_out(2'd0, 1'b0, 1'b0, 1'b0, "R5 too fast");

        // loss of word clock
        set_rate(256, 256); cycles(7000);
        expect_out(2'd1, 1'b0, 1'b1, 1'b1, "R7 locked before stop");
        run = 1'b0;
        cycles(2000);
        expect_out(2'd1, 1'b0, 1'b1, 1'b1, "R7 held before limit");
        cycles(2700);
        expect_out(2'd0, 1'b0, 1'b0, 1'b0, "R7 timed out");
        run = 1'b1;
        cycles(7000);
        expect_out(2'd1, 1'b0, 1'b1, 1'b1, "R7/R9 recovered");

        while (sb_q.size() > 0) cycles(1);
        cycles(2);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule